// File: doc/BRIEF.md
# Register Bank with Per-Group Write Ownership

This block holds thirteen 16-bit data registers and one control word at fixed word addresses. The data registers fall into three groups: eight processor-interface words at addresses 2048 to 2055, one pin-state word at 2056, and four auxiliary-converter words at 2057 to 2060. The control word sits at 2076.

Normally each group is written by its internal producer. The processor program writes one interface word per cycle by index. The pin logic and the converter each present a value with a valid strobe, and each of the four converter lanes has its own strobe. Three bits in the control word can hand a group over to the external control port instead. While the port owns a group, the internal producer's updates to it are dropped. While the producer owns a group, port writes to it are dropped.

Every register can be read back through the control port whichever source owns it. A read returns a registered result one cycle after the request.

Top module: `regbank_top`

## Requirements
- R1: After reset every data register and the control word read as 0x0000, and `cp_rd_ack`, `cp_rd_hit` and `cp_rd_data` are 0.
- R2: The control word at address 2076 stores bits 13, 12 and 8 to 0 as written. Bits 15, 14 and 11 to 9 always read 0, and writes to them have no effect.
- R3: With control bit 6 clear, a processor write with index 0 to 7 updates the interface word at 2048 plus that index, and port writes to 2048 to 2055 are dropped.
- R4: With control bit 6 set, port writes to 2048 to 2055 update those words, and processor writes are dropped.
- R5: With control bit 7 clear, a valid pin update loads the word at 2056, and port writes to 2056 are dropped.
- R6: With control bit 7 set, port writes to 2056 load it, and pin updates are dropped.
- R7: With control bit 8 clear, each converter lane i (0 to 3, data at bits 16i+15 to 16i) whose valid bit is set loads the word at 2057 plus i. Lanes whose valid bit is clear keep their value, and port writes to 2057 to 2060 are dropped.
- R8: With control bit 8 set, port writes to 2057 to 2060 load those words, and converter updates are dropped.
- R9: A read request sampled at a clock edge sets `cp_rd_ack` after that edge, together with the value the register held before that edge. A write landing on the same edge is not visible until the next read.
- R10: Addresses outside 2048 to 2060 and other than 2076 are not decoded. A read of one gives `cp_rd_hit` = 0 and data 0, and a write to one changes no register.
- R11: Ownership is taken from the control word held before the edge. A control-word write changes ownership only for updates on later cycles.
- R12: In a cycle after no read request, `cp_rd_ack`, `cp_rd_hit` and `cp_rd_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cp_wr_en | input | 1 | Control-port write strobe |
| cp_wr_addr | input | 12 | Control-port write word address |
| cp_wr_data | input | 16 | Control-port write data |
| cp_rd_en | input | 1 | Control-port read request |
| cp_rd_addr | input | 12 | Control-port read word address |
| cp_rd_ack | output | 1 | Read result valid, one cycle after the request |
| cp_rd_hit | output | 1 | The read address was decoded |
| cp_rd_data | output | 16 | Read result |
| prog_wr_en | input | 1 | Processor-program write strobe for interface words |
| prog_wr_idx | input | 3 | Interface word index |
| prog_wr_data | input | 16 | Processor-program write data |
| pin_upd_valid | input | 1 | Pin-state update strobe |
| pin_upd_data | input | 16 | Pin-state value |
| aux_upd_valid | input | 4 | Per-lane converter update strobes |
| aux_upd_data | input | 64 | Converter lane values, lane i at bits 16i+15 to 16i |

## Verification
Every write, whether from the port or from an internal producer, lands on the next rising edge. Every read result appears on the outputs after the edge that samples the request. The bench drives inputs on falling edges and pushes each expected read result into a queue at the moment it issues the request. A monitor pops and compares the queue on the falling edge where `cp_rd_ack` is high, which is exactly one cycle after the request. Same-edge cases are driven deliberately in single cycles: a read colliding with a write, and a control-word write colliding with a producer update. This pins down the before-the-edge semantics of R9 and R11.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  parameter int RB_DW       = 16;
  parameter int RB_AW       = 12;
  parameter int RB_IF_BASE  = 2048;
  parameter int RB_IF_CNT   = 8;
  parameter int RB_AUX_CNT  = 4;
  parameter int RB_CTL_ADDR = 2076;

  // ownership bit positions inside the control word
  parameter int OWN_IF_BIT   = 6;
  parameter int OWN_PIN_BIT  = 7;
  parameter int OWN_AUX_BIT  = 8;

  // writable control bits: 13,12 and 8..0
  parameter logic [15:0] CTL_WMASK = 16'h31FF;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_IF   = 3'd1,
    SEL_PIN  = 3'd2,
    SEL_AUX  = 3'd3,
    SEL_CTL  = 3'd4
  } rb_sel_e;

endpackage

// File: rtl/regbank_decode.sv
module regbank_decode
  import regbank_pkg::*;
#(
  parameter int AW       = RB_AW,
  parameter int IF_BASE  = RB_IF_BASE,
  parameter int IF_CNT   = RB_IF_CNT,
  parameter int AUX_CNT  = RB_AUX_CNT,
  parameter int CTL_ADDR = RB_CTL_ADDR,
  parameter int IDX_W    = 3
) (
  input  logic [AW-1:0]    addr,
  output rb_sel_e          sel,
  output logic [IDX_W-1:0] idx
);
  localparam int PIN_ADDR = IF_BASE + IF_CNT;
  localparam int AUX_BASE = PIN_ADDR + 1;
  localparam int AUX_END  = AUX_BASE + AUX_CNT;

  int a;

  always_comb begin
    a   = int'(addr);
    sel = SEL_NONE;
    idx = '0;
    if (a >= IF_BASE && a < PIN_ADDR) begin
      sel = SEL_IF;
      idx = IDX_W'(a - IF_BASE);
    end else if (a == PIN_ADDR) begin
      sel = SEL_PIN;
    end else if (a >= AUX_BASE && a < AUX_END) begin
      sel = SEL_AUX;
      idx = IDX_W'(a - AUX_BASE);
    end else if (a == CTL_ADDR) begin
      sel = SEL_CTL;
    end
  end

endmodule

// File: rtl/regbank_ctrl.sv
module regbank_ctrl #(
  parameter int          DW    = 16,
  parameter logic [15:0] WMASK = 16'h31FF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam logic [DW-1:0] MASK = DW'(WMASK);

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= wdata & MASK;
  end

endmodule

// File: rtl/regbank_group.sv
module regbank_group #(
  parameter int DW    = 16,
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            own_cp,
  input  logic            cp_we,
  input  logic [IDX_W-1:0] cp_idx,
  input  logic [DW-1:0]   cp_wdata,
  input  logic [N-1:0]    int_we,
  input  logic [N*DW-1:0] int_wdata,
  output logic [N*DW-1:0] q_flat
);

  for (genvar i = 0; i < N; i++) begin : g_word
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else if (own_cp) begin
        if (cp_we && cp_idx == IDX_W'(i)) q <= cp_wdata;
      end else if (int_we[i]) begin
        q <= int_wdata[i*DW +: DW];
      end
    end
    assign q_flat[i*DW +: DW] = q;
  end

endmodule

// File: rtl/regbank_rdmux.sv
module regbank_rdmux
  import regbank_pkg::*;
#(
  parameter int DW      = 16,
  parameter int IF_CNT  = 8,
  parameter int AUX_CNT = 4,
  parameter int IDX_W   = 3
) (
  input  rb_sel_e              sel,
  input  logic [IDX_W-1:0]     idx,
  input  logic [IF_CNT*DW-1:0] if_flat,
  input  logic [DW-1:0]        pin_q,
  input  logic [AUX_CNT*DW-1:0] aux_flat,
  input  logic [DW-1:0]        ctl_q,
  output logic                 hit,
  output logic [DW-1:0]        data
);

  always_comb begin
    hit  = 1'b1;
    data = '0;
    case (sel)
      SEL_IF:  data = if_flat[int'(idx)*DW +: DW];
      SEL_PIN: data = pin_q;
      SEL_AUX: data = aux_flat[int'(idx)*DW +: DW];
      SEL_CTL: data = ctl_q;
      default: hit  = 1'b0;
    endcase
  end

endmodule

// File: rtl/regbank_top.sv
module regbank_top
  import regbank_pkg::*;
#(
  parameter int DW       = RB_DW,
  parameter int AW       = RB_AW,
  parameter int IF_CNT   = RB_IF_CNT,
  parameter int AUX_CNT  = RB_AUX_CNT,
  parameter int IF_IDX_W = $clog2(IF_CNT)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cp_wr_en,
  input  logic [AW-1:0]         cp_wr_addr,
  input  logic [DW-1:0]         cp_wr_data,
  input  logic                  cp_rd_en,
  input  logic [AW-1:0]         cp_rd_addr,
  output logic                  cp_rd_ack,
  output logic                  cp_rd_hit,
  output logic [DW-1:0]         cp_rd_data,
  input  logic                  prog_wr_en,
  input  logic [IF_IDX_W-1:0]   prog_wr_idx,
  input  logic [DW-1:0]         prog_wr_data,
  input  logic                  pin_upd_valid,
  input  logic [DW-1:0]         pin_upd_data,
  input  logic [AUX_CNT-1:0]    aux_upd_valid,
  input  logic [AUX_CNT*DW-1:0] aux_upd_data
);
  localparam int MAX_CNT = (IF_CNT > AUX_CNT) ? IF_CNT : AUX_CNT;
  localparam int IDX_W   = (MAX_CNT > 1) ? $clog2(MAX_CNT) : 1;

  rb_sel_e          wr_sel, rd_sel;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [DW-1:0]    ctl_q;
  logic [IF_CNT*DW-1:0]  if_flat;
  logic [DW-1:0]         pin_q;
  logic [AUX_CNT*DW-1:0] aux_flat;
  logic [IF_CNT-1:0]     prog_we_vec;
  logic [IF_CNT*DW-1:0]  prog_data_vec;
  logic                  mux_hit;
  logic [DW-1:0]         mux_data;

  // ownership, taken from the registered control word
  logic own_if, own_pin, own_aux;
  assign own_if  = ctl_q[OWN_IF_BIT];
  assign own_pin = ctl_q[OWN_PIN_BIT];
  assign own_aux = ctl_q[OWN_AUX_BIT];

  regbank_decode #(.AW(AW), .IF_CNT(IF_CNT), .AUX_CNT(AUX_CNT), .IDX_W(IDX_W))
    u_wr_dec (.addr(cp_wr_addr), .sel(wr_sel), .idx(wr_idx));

  regbank_decode #(.AW(AW), .IF_CNT(IF_CNT), .AUX_CNT(AUX_CNT), .IDX_W(IDX_W))
    u_rd_dec (.addr(cp_rd_addr), .sel(rd_sel), .idx(rd_idx));

  regbank_ctrl #(.DW(DW), .WMASK(CTL_WMASK)) u_ctrl (
    .clk(clk), .rst(rst),
    .we(cp_wr_en && wr_sel == SEL_CTL),
    .wdata(cp_wr_data), .q(ctl_q)
  );

  // processor index to per-word strobes
  for (genvar i = 0; i < IF_CNT; i++) begin : g_prog
    assign prog_we_vec[i] = prog_wr_en && (prog_wr_idx == IF_IDX_W'(i));
    assign prog_data_vec[i*DW +: DW] = prog_wr_data;
  end

  regbank_group #(.DW(DW), .N(IF_CNT), .IDX_W(IDX_W)) u_if_grp (
    .clk(clk), .rst(rst), .own_cp(own_if),
    .cp_we(cp_wr_en && wr_sel == SEL_IF), .cp_idx(wr_idx), .cp_wdata(cp_wr_data),
    .int_we(prog_we_vec), .int_wdata(prog_data_vec), .q_flat(if_flat)
  );

  regbank_group #(.DW(DW), .N(1), .IDX_W(IDX_W)) u_pin_grp (
    .clk(clk), .rst(rst), .own_cp(own_pin),
    .cp_we(cp_wr_en && wr_sel == SEL_PIN), .cp_idx(wr_idx), .cp_wdata(cp_wr_data),
    .int_we(pin_upd_valid), .int_wdata(pin_upd_data), .q_flat(pin_q)
  );

  regbank_group #(.DW(DW), .N(AUX_CNT), .IDX_W(IDX_W)) u_aux_grp (
    .clk(clk), .rst(rst), .own_cp(own_aux),
    .cp_we(cp_wr_en && wr_sel == SEL_AUX), .cp_idx(wr_idx), .cp_wdata(cp_wr_data),
    .int_we(aux_upd_valid), .int_wdata(aux_upd_data), .q_flat(aux_flat)
  );

  regbank_rdmux #(.DW(DW), .IF_CNT(IF_CNT), .AUX_CNT(AUX_CNT), .IDX_W(IDX_W)) u_rdmux (
    .sel(rd_sel), .idx(rd_idx), .if_flat(if_flat), .pin_q(pin_q),
    .aux_flat(aux_flat), .ctl_q(ctl_q), .hit(mux_hit), .data(mux_data)
  );

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      cp_rd_ack  <= 1'b0;
      cp_rd_hit  <= 1'b0;
      cp_rd_data <= '0;
    end else begin
      cp_rd_ack  <= cp_rd_en;
      cp_rd_hit  <= cp_rd_en && mux_hit;
      cp_rd_data <= cp_rd_en ? mux_data : '0;
    end
  end

endmodule

// File: rtl/regbank_chk.sv
module regbank_chk
  import regbank_pkg::*;
#(
  parameter int DW     = RB_DW,
  parameter int AW     = RB_AW,
  parameter int IF_CNT = RB_IF_CNT
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cp_wr_en,
  input logic [AW-1:0]        cp_wr_addr,
  input logic                 cp_rd_en,
  input logic [AW-1:0]        cp_rd_addr,
  input logic                 cp_rd_ack,
  input logic                 cp_rd_hit,
  input logic [DW-1:0]        cp_rd_data,
  input logic                 pin_upd_valid,
  input logic [DW-1:0]        ctl_q,
  input logic [DW-1:0]        pin_q,
  input logic [IF_CNT*DW-1:0] if_flat
);
  localparam int PIN_ADDR = RB_IF_BASE + IF_CNT;
  localparam int LAST     = PIN_ADDR + RB_AUX_CNT;
  localparam logic [DW-1:0] RSVD = ~DW'(CTL_WMASK);

  logic cp_to_pin, cp_to_if, rd_undecoded;
  assign cp_to_pin = cp_wr_en && int'(cp_wr_addr) == PIN_ADDR;
  assign cp_to_if  = cp_wr_en && int'(cp_wr_addr) >= RB_IF_BASE && int'(cp_wr_addr) < PIN_ADDR;
  assign rd_undecoded = (int'(cp_rd_addr) < RB_IF_BASE) ||
                        (int'(cp_rd_addr) > LAST && int'(cp_rd_addr) != RB_CTL_ADDR);

  assert_rd_ack_R9: assert property (@(posedge clk) disable iff (rst)
    cp_rd_en |=> cp_rd_ack);

  assert_idle_zero_R12: assert property (@(posedge clk) disable iff (rst)
    !cp_rd_en |=> (!cp_rd_ack && !cp_rd_hit && cp_rd_data == '0));

  assert_rsvd_read_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (cp_rd_en && int'(cp_rd_addr) == RB_CTL_ADDR) |=> ((cp_rd_data & RSVD) == '0));

  assert_undecoded_R10: assert property (@(posedge clk) disable iff (rst)
    (cp_rd_en && rd_undecoded) |=> (!cp_rd_hit && cp_rd_data == '0));

  assert_pin_cp_dropped_R5: assert property (@(posedge clk) disable iff (rst)
    (!ctl_q[OWN_PIN_BIT] && !pin_upd_valid) |=> $stable(pin_q));

  assert_pin_upd_dropped_R6: assert property (@(posedge clk) disable iff (rst)
    (ctl_q[OWN_PIN_BIT] && !cp_to_pin) |=> $stable(pin_q));

  assert_prog_dropped_R4: assert property (@(posedge clk) disable iff (rst)
    (ctl_q[OWN_IF_BIT] && !cp_to_if) |=> $stable(if_flat));

endmodule

bind regbank_top regbank_chk #(.DW(DW), .AW(AW), .IF_CNT(IF_CNT)) u_chk (
  .clk(clk), .rst(rst), .cp_wr_en(cp_wr_en), .cp_wr_addr(cp_wr_addr),
  .cp_rd_en(cp_rd_en), .cp_rd_addr(cp_rd_addr), .cp_rd_ack(cp_rd_ack),
  .cp_rd_hit(cp_rd_hit), .cp_rd_data(cp_rd_data), .pin_upd_valid(pin_upd_valid),
  .ctl_q(ctl_q), .pin_q(pin_q), .if_flat(if_flat)
);

// File: tb/tb_regbank_top.sv
`timescale 1ns/1ps
module tb_regbank_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cp_wr_en = 0;
  logic [11:0] cp_wr_addr = '0;
  logic [15:0] cp_wr_data = '0;
  logic        cp_rd_en = 0;
  logic [11:0] cp_rd_addr = '0;
  logic        cp_rd_ack, cp_rd_hit;
  logic [15:0] cp_rd_data;
  logic        prog_wr_en = 0;
  logic [2:0]  prog_wr_idx = '0;
  logic [15:0] prog_wr_data = '0;
  logic        pin_upd_valid = 0;
  logic [15:0] pin_upd_data = '0;
  logic [3:0]  aux_upd_valid = '0;
  logic [63:0] aux_upd_data = '0;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [16:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  regbank_top dut (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compare each read result on the cycle it is due
  always @(negedge clk) begin
    if (!rst && cp_rd_ack) begin
      if (exp_q.size() == 0) begin
        check("R9 unexpected ack", 32'(cp_rd_ack), 32'h0);
      end else begin
        automatic logic [16:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, {15'h0, cp_rd_hit, cp_rd_data}, {15'h0, e});
      end
    end
  end

  task automatic cp_write(int addr, logic [15:0] d);
    @(negedge clk);
    cp_wr_en = 1; cp_wr_addr = 12'(addr); cp_wr_data = d;
    @(negedge clk);
    cp_wr_en = 0;
  endtask

  task automatic rd(int addr, logic hit, logic [15:0] d, string tag);
    @(negedge clk);
    cp_rd_en = 1; cp_rd_addr = 12'(addr);
    exp_q.push_back({hit, d}); tag_q.push_back(tag);
    @(negedge clk);
    cp_rd_en = 0;
  endtask

  task automatic prog_write(int idx, logic [15:0] d);
    @(negedge clk);
    prog_wr_en = 1; prog_wr_idx = 3'(idx); prog_wr_data = d;
    @(negedge clk);
    prog_wr_en = 0;
  endtask

  task automatic pin_upd(logic [15:0] d);
    @(negedge clk);
    pin_upd_valid = 1; pin_upd_data = d;
    @(negedge clk);
    pin_upd_valid = 0;
  endtask

  task automatic aux_upd(logic [3:0] v, logic [63:0] d);
    @(negedge clk);
    aux_upd_valid = v; aux_upd_data = d;
    @(negedge clk);
    aux_upd_valid = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ack in reset", {cp_rd_ack, cp_rd_hit, cp_rd_data}, 32'h0);
    rst = 0;

    // R1 reset values
    rd(2076, 1, 16'h0000, "R1 ctl reset");
    rd(2048, 1, 16'h0000, "R1 if0 reset");
    rd(2056, 1, 16'h0000, "R1 pin reset");
    rd(2060, 1, 16'h0000, "R1 aux3 reset");

    // R2 reserved bits
    cp_write(2076, 16'hFFFF);
    rd(2076, 1, 16'h31FF, "R2 ctl mask");
    cp_write(2076, 16'h0000);
    rd(2076, 1, 16'h0000, "R2 ctl clear");

    // R3 processor owns interface words
    prog_write(3, 16'h1234);
    rd(2051, 1, 16'h1234, "R3 prog write");
    cp_write(2051, 16'hAAAA);
    rd(2051, 1, 16'h1234, "R3 cp dropped");

    // R4 port owns interface words
    cp_write(2076, 16'h0040);
    cp_write(2055, 16'hBEEF);
    rd(2055, 1, 16'hBEEF, "R4 cp write");
    prog_write(7, 16'h1111);
    rd(2055, 1, 16'hBEEF, "R4 prog dropped");

    // R5 pins own pin word
    pin_upd(16'h00A5);
    rd(2056, 1, 16'h00A5, "R5 pin update");
    cp_write(2056, 16'h5555);
    rd(2056, 1, 16'h00A5, "R5 cp dropped");

    // R6 port owns pin word
    cp_write(2076, 16'h0080);
    cp_write(2056, 16'h5A5A);
    rd(2056, 1, 16'h5A5A, "R6 cp write");
    pin_upd(16'h0001);
    rd(2056, 1, 16'h5A5A, "R6 pin dropped");
    prog_write(7, 16'h2222);
    rd(2055, 1, 16'h2222, "R3 prog owns again");

    // R7 converter owns aux words
    cp_write(2076, 16'h0000);
    aux_upd(4'b0101, {16'h0, 16'h0300, 16'h0, 16'h0100});
    rd(2057, 1, 16'h0100, "R7 lane0");
    rd(2058, 1, 16'h0000, "R7 lane1 held");
    rd(2059, 1, 16'h0300, "R7 lane2");
    cp_write(2060, 16'h7777);
    rd(2060, 1, 16'h0000, "R7 cp dropped");

    // R8 port owns aux words
    cp_write(2076, 16'h0100);
    cp_write(2060, 16'h7777);
    rd(2060, 1, 16'h7777, "R8 cp write");
    aux_upd(4'b1111, {4{16'hFFFF}});
    rd(2057, 1, 16'h0100, "R8 lane0 dropped");
    rd(2060, 1, 16'h7777, "R8 lane3 dropped");

    // R10 undecoded addresses
    cp_write(2070, 16'h9999);
    rd(2070, 0, 16'h0000, "R10 read 2070");
    rd(2061, 0, 16'h0000, "R10 read 2061");
    rd(2047, 0, 16'h0000, "R10 read 2047");
    rd(2076, 1, 16'h0100, "R10 ctl untouched");

    // R11 ownership change takes effect after the edge
    cp_write(2076, 16'h0080);
    @(negedge clk);
    cp_wr_en = 1; cp_wr_addr = 12'd2076; cp_wr_data = 16'h0000;
    pin_upd_valid = 1; pin_upd_data = 16'h0F0F;
    @(negedge clk);
    cp_wr_en = 0; pin_upd_valid = 0;
    rd(2056, 1, 16'h5A5A, "R11 same-cycle update dropped");
    pin_upd(16'h0F0F);
    rd(2056, 1, 16'h0F0F, "R11 update after change");

    // R9 read colliding with write sees old value
    @(negedge clk);
    cp_rd_en = 1; cp_rd_addr = 12'd2056;
    exp_q.push_back({1'b1, 16'h0F0F}); tag_q.push_back("R9 read before write");
    pin_upd_valid = 1; pin_upd_data = 16'h00FF;
    @(negedge clk);
    cp_rd_en = 0; pin_upd_valid = 0;
    rd(2056, 1, 16'h00FF, "R9 next read sees write");

    // R12 idle outputs
    @(negedge clk);
    check("R12 idle outputs", {cp_rd_ack, cp_rd_hit, cp_rd_data}, 32'h0);

    repeat (2) @(negedge clk);
    check("R9 all reads answered", 32'(exp_q.size()), 32'h0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule